// File: doc/BRIEF.md
# Counted-Burst Buffer Port Engine

This block puts a 16-bit processor bus in front of an internal word buffer and a handful of control registers, using only two ports. The ports share one select line. The two low address bits tell the command port from the data port. Every transaction begins with a command word written to the command port. Bit 7 of that word gives the direction, and bits 6:0 pick the target. If the target is a register, the following data-port accesses carry that register's value. A two-word register sends its upper half first.

If the target is the buffer, there is no address to supply. The following data-port accesses stream consecutive words, starting from word zero. The burst length comes from a byte count held in a separate register, and the engine stops after that many bytes' worth of words. A single-cycle completion pulse marks the end of each burst.

An access that breaks the protocol is dropped and sets a sticky error flag. Three cases count as a break: a data access in the wrong direction, a data access with no open command, and a data access after the count has run out. Software reads the flag back through a status register.

Top module: `bufport_engine`

## Requirements
- R1: A bus access is taken only when select is high and exactly one of read and write is high. Address 2'b11 is the command port and 2'b10 is the data port. Accesses to 2'b00 and 2'b01 change no state.
- R2: In a command word, bit 7 set means write and bits 6:0 are the target index. Index 0x22 is the 16-bit byte-count register, so 0x00A2 writes it and 0x0022 reads it.
- R3: Index 0x40 is the buffer (0x00C0 write, 0x0040 read). Accepting a buffer command sets the word pointer to 0. Each accepted data access moves one word at the pointer and then increments the pointer.
- R4: A buffer burst lasts ceil(count/2) data accesses, so an odd byte count is rounded up to a whole word. After the last access the engine waits for a new command.
- R5: A buffer command issued while the count is zero ends the burst at once, with no data phase.
- R6: A data access whose direction differs from bit 7 of the open command is ignored. It does not write, does not advance the pointer and does not use up the count, and it sets the sticky error flag. Status is index 0x24, and its read value is {15'b0, error}. A data write after command 0x00A4 clears the flag.
- R7: A data access made while no command is open is ignored and sets the error flag. This covers accesses after a burst or register phase has finished.
- R8: Index 0x28 is a 32-bit scratch register moved in two data phases, bits 31:16 first and bits 15:0 second. A third data access is an error.
- R9: The completion output pulses high for exactly the one cycle after the edge that takes the final burst word, or after the edge that takes a zero-count buffer command.
- R10: A command write made during an open burst or register phase abandons it without a completion pulse and starts the new command.
- R11: After reset the engine waits for a command, and the count, the error flag and the completion output are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Select for both ports |
| bus_addr | input | 2 | Port address, 11 command, 10 data |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 16 | Write data or command word |
| bus_rdata | output | 16 | Read data, combinational, valid in the access cycle |
| burst_done | output | 1 | One-cycle completion pulse |

## Verification
The completion pulse from a finishing burst can land in the same cycle as the acceptance of the next command. The bench provokes this by writing the last buffer word and then issuing a buffer-read command in the very next cycle. It checks that the pulse is seen during that command cycle. It then checks that the new burst starts cleanly from word zero and produces its own pulse. The error flag can also be raised in the middle of a burst. The bench inserts a wrong-direction access between two good writes and then reads the buffer back, to show that neither the pointer nor the remaining count moved.

// File: rtl/bufport_pkg.sv
package bufport_pkg;

    localparam int WORD_W = 16;

    localparam logic [1:0] PORT_CMD  = 2'b11;
    localparam logic [1:0] PORT_DATA = 2'b10;

    localparam logic [6:0] IDX_COUNT   = 7'h22;
    localparam logic [6:0] IDX_STATUS  = 7'h24;
    localparam logic [6:0] IDX_SCRATCH = 7'h28;
    localparam logic [6:0] IDX_BUFFER  = 7'h40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REG  = 2'd1,
        ST_BUF  = 2'd2
    } phase_e;

    typedef struct packed {
        logic       is_write;
        logic [6:0] index;
    } cmd_t;

    typedef struct packed {
        logic              cmd_wr;
        logic              data_wr;
        logic              data_rd;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    // byte count to word count, rounding an odd byte up
    function automatic logic [WORD_W-1:0] words_for_bytes(input logic [WORD_W-1:0] bytes);
        return (bytes >> 1) + {{(WORD_W-1){1'b0}}, bytes[0]};
    endfunction

    // index of the final data phase of a register command
    function automatic logic last_phase(input logic [6:0] idx);
        return (idx == IDX_SCRATCH);
    endfunction

endpackage

// File: rtl/bufport_decode.sv
module bufport_decode
    import bufport_pkg::*;
(
    input  logic              sel,
    input  logic [1:0]        addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output bus_req_t          req
);
    logic one_strobe;

    always_comb begin
        one_strobe  = sel && (rd ^ wr);
        req.cmd_wr  = one_strobe && wr && (addr == PORT_CMD);
        req.data_wr = one_strobe && wr && (addr == PORT_DATA);
        req.data_rd = one_strobe && rd && (addr == PORT_DATA);
        req.wdata   = wdata;
    end
endmodule

// File: rtl/bufport_regs.sv
module bufport_regs
    import bufport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [6:0]        reg_idx,
    input  logic              reg_phase,
    input  logic [WORD_W-1:0] wdata,
    input  logic              err_set,
    output logic [WORD_W-1:0] count,
    output logic              err,
    output logic [WORD_W-1:0] rd_word
);
    logic [2*WORD_W-1:0] scratch;

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            scratch <= '0;
            err     <= 1'b0;
        end else begin
            if (err_set)
                err <= 1'b1;
            if (reg_wr) begin
                case (reg_idx)
                    IDX_COUNT:  count <= wdata;
                    IDX_STATUS: err   <= 1'b0;
                    IDX_SCRATCH: begin
                        if (reg_phase) scratch[WORD_W-1:0]        <= wdata;
                        else           scratch[2*WORD_W-1:WORD_W] <= wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_idx)
            IDX_COUNT:   rd_word = count;
            IDX_STATUS:  rd_word = {{(WORD_W-1){1'b0}}, err};
            IDX_SCRATCH: rd_word = reg_phase ? scratch[WORD_W-1:0]
                                             : scratch[2*WORD_W-1:WORD_W];
            default:     rd_word = '0;
        endcase
    end
endmodule

// File: rtl/bufport_ram.sv
module bufport_ram
    import bufport_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/bufport_seq.sv
module bufport_seq
    import bufport_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [WORD_W-1:0] count,
    output phase_e            state,
    output cmd_t              cmd,
    output logic              phase,
    output logic [PTR_W-1:0]  ptr,
    output logic [WORD_W-1:0] left,
    output logic              acc_ok,
    output logic              reg_wr,
    output logic              ram_we,
    output logic              err_set,
    output logic              done
);
    logic              data_acc;
    logic              dir_ok;
    cmd_t              new_cmd;
    logic [WORD_W-1:0] new_words;

    always_comb begin
        data_acc  = req.data_wr || req.data_rd;
        dir_ok    = (req.data_wr == cmd.is_write);
        acc_ok    = data_acc && (state != ST_IDLE) && dir_ok;
        err_set   = data_acc && !acc_ok;
        reg_wr    = acc_ok && (state == ST_REG) && req.data_wr;
        ram_we    = acc_ok && (state == ST_BUF) && req.data_wr;
        new_cmd   = cmd_t'(req.wdata[7:0]);
        new_words = words_for_bytes(count);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd   <= '0;
            phase <= 1'b0;
            ptr   <= '0;
            left  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (req.cmd_wr) begin
                cmd   <= new_cmd;
                phase <= 1'b0;
                if (new_cmd.index == IDX_BUFFER) begin
                    ptr  <= '0;
                    left <= new_words;
                    if (new_words == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state <= ST_BUF;
                    end
                end else begin
                    left  <= '0;
                    state <= ST_REG;
                end
            end else if (acc_ok) begin
                if (state == ST_REG) begin
                    phase <= ~phase;
                    if (phase == last_phase(cmd.index))
                        state <= ST_IDLE;
                end else begin
                    ptr  <= ptr + 1'b1;
                    left <= left - 1'b1;
                    if (left == {{(WORD_W-1){1'b0}}, 1'b1}) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/bufport_engine.sv
module bufport_engine
    import bufport_pkg::*;
#(
    parameter int RAM_DEPTH = 256,
    localparam int PTR_W = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic [1:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              burst_done
);
    bus_req_t          req;
    phase_e            state;
    cmd_t              cmd;
    logic              phase;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] left;
    logic              acc_ok;
    logic              reg_wr;
    logic              ram_we;
    logic              err_set;
    logic [WORD_W-1:0] count;
    logic              err;
    logic [WORD_W-1:0] reg_word;
    logic [WORD_W-1:0] ram_word;

    bufport_decode u_dec (
        .sel   (bus_sel),
        .addr  (bus_addr),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .req   (req)
    );

    bufport_seq #(.PTR_W(PTR_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .count   (count),
        .state   (state),
        .cmd     (cmd),
        .phase   (phase),
        .ptr     (ptr),
        .left    (left),
        .acc_ok  (acc_ok),
        .reg_wr  (reg_wr),
        .ram_we  (ram_we),
        .err_set (err_set),
        .done    (burst_done)
    );

    bufport_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_idx   (cmd.index),
        .reg_phase (phase),
        .wdata     (req.wdata),
        .err_set   (err_set),
        .count     (count),
        .err       (err),
        .rd_word   (reg_word)
    );

    bufport_ram #(.DEPTH(RAM_DEPTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ptr),
        .wdata (req.wdata),
        .raddr (ptr),
        .rdata (ram_word)
    );

    always_comb begin
        if (req.data_rd && acc_ok)
            bus_rdata = (state == ST_REG) ? reg_word : ram_word;
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/bufport_chk.sv
module bufport_chk
    import bufport_pkg::*;
#(
    parameter int PTR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input bus_req_t          req,
    input phase_e            state,
    input cmd_t              cmd,
    input logic              acc_ok,
    input logic [PTR_W-1:0]  ptr,
    input logic [WORD_W-1:0] left,
    input logic              ram_we,
    input logic              reg_wr,
    input logic              done,
    input logic              err
);
    logic any_acc;
    logic err_clear;
    assign any_acc   = req.cmd_wr || req.data_wr || req.data_rd;
    assign err_clear = reg_wr && (cmd.index == IDX_STATUS);

    // R3: pointer starts at word zero after a buffer command
    a_r3_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
        (req.cmd_wr && req.wdata[6:0] == IDX_BUFFER) |=> (ptr == '0));

    // R4: each good buffer access uses exactly one word of the count
    a_r4_left_steps: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUF && acc_ok && !req.cmd_wr) |=> (left == $past(left) - 1'b1));

    // R6: the buffer is written only by a write access in a write burst
    a_r6_ram_we_dir: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (state == ST_BUF && cmd.is_write && req.data_wr));

    // R7: the error flag holds until it is cleared
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clear) |=> err);

    // R9: a completion pulse always follows an accepted access
    a_r9_done_after_access: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(any_acc));

    // R11: state right after reset
    a_r11_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !err && state == ST_IDLE));
endmodule

bind bufport_engine bufport_chk #(.PTR_W(PTR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req    (req),
    .state  (state),
    .cmd    (cmd),
    .acc_ok (acc_ok),
    .ptr    (ptr),
    .left   (left),
    .ram_we (ram_we),
    .reg_wr (reg_wr),
    .done   (burst_done),
    .err    (err)
);

// File: tb/bufport_engine_tb_top.sv
module bufport_engine_tb_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic [1:0]  bus_addr = 2'b00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        burst_done;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [15:0] got;
    logic        gdone;

    always #(CLK_NS/2) clk = ~clk;

    bufport_engine dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_addr   (bus_addr),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .burst_done (burst_done)
    );

    // op: 0 idle, 1 command write, 2 data write, 3 data read (data = expected)
    // fields {op[1:0], expected completion in this cycle, data[15:0]}
    localparam int NV = 14;
    localparam logic [18:0] VEC [NV] = '{
        {2'd1, 1'b0, 16'h00A2},   // R2 write count
        {2'd2, 1'b0, 16'h0006},
        {2'd1, 1'b0, 16'h00C0},   // R3 buffer write
        {2'd2, 1'b0, 16'h1111},
        {2'd2, 1'b0, 16'h2222},
        {2'd2, 1'b0, 16'h3333},
        {2'd0, 1'b1, 16'h0000},   // R9 pulse after last word
        {2'd1, 1'b0, 16'h0022},   // R2 read count
        {2'd3, 1'b0, 16'h0006},
        {2'd1, 1'b0, 16'h0040},   // R3 buffer read
        {2'd3, 1'b0, 16'h1111},
        {2'd3, 1'b0, 16'h2222},
        {2'd3, 1'b0, 16'h3333},
        {2'd0, 1'b1, 16'h0000}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic [1:0] a, input logic r, input logic w,
                       input logic [15:0] d);
        @(negedge clk);
        bus_sel = s; bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
        #3;
        got   = bus_rdata;
        gdone = burst_done;
    endtask

    task automatic cmdw(input logic [15:0] c);
        cyc(1'b1, 2'b11, 1'b0, 1'b1, c);
    endtask

    task automatic dwr(input logic [15:0] d);
        cyc(1'b1, 2'b10, 1'b0, 1'b1, d);
    endtask

    task automatic drd(input string tag, input logic [15:0] exp);
        cyc(1'b1, 2'b10, 1'b1, 1'b0, 16'h0000);
        chk(tag, got, exp);
    endtask

    task automatic idle_done(input string tag, input logic exp);
        cyc(1'b0, 2'b00, 1'b0, 1'b0, 16'h0000);
        chk(tag, {15'b0, gdone}, {15'b0, exp});
    endtask

    task automatic status(input string tag, input logic exp);
        cmdw(16'h0024);
        drd(tag, {15'b0, exp});
    endtask

    task automatic clear_err();
        cmdw(16'h00A4);
        dwr(16'h0000);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        idle_done("R11 done after reset", 1'b0);
        status("R11 error after reset", 1'b0);
        cmdw(16'h0022);
        drd("R11 count after reset", 16'h0000);

        // table walk: R2 R3 R4 R9
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic        ed;
            logic [15:0] dv;
            {op, ed, dv} = VEC[i];
            case (op)
                2'd0: cyc(1'b0, 2'b00, 1'b0, 1'b0, 16'h0000);
                2'd1: cmdw(dv);
                2'd2: dwr(dv);
                default: begin
                    cyc(1'b1, 2'b10, 1'b1, 1'b0, 16'h0000);
                    chk("R3 table read data", got, dv);
                end
            endcase
            chk("R9 table completion", {15'b0, gdone}, {15'b0, ed});
        end

        // R4 odd count rounds up: 5 bytes -> 3 words
        cmdw(16'h00A2); dwr(16'h0005);
        cmdw(16'h00C0); dwr(16'hAAAA); dwr(16'hBBBB);
        idle_done("R4 no pulse before last word", 1'b0);
        dwr(16'hCCCC);
        idle_done("R4 pulse after third word", 1'b1);

        // R7 data write with no open command
        dwr(16'hDDDD);
        status("R7 error after stray write", 1'b1);
        clear_err();
        status("R6 error cleared", 1'b0);
        cmdw(16'h0040);
        drd("R7 word0 untouched", 16'hAAAA);
        drd("R7 word1 untouched", 16'hBBBB);
        drd("R4 word2", 16'hCCCC);
        idle_done("R4 read burst pulse", 1'b1);

        // R6 wrong direction inside a write burst
        cmdw(16'h00A2); dwr(16'h0004);
        cmdw(16'h00C0); dwr(16'h1234);
        drd("R6 wrong-direction read returns zero", 16'h0000);
        dwr(16'h5678);
        idle_done("R6 count not used by wrong access", 1'b1);
        status("R6 error set", 1'b1);
        clear_err();
        cmdw(16'h0040);
        drd("R6 word0", 16'h1234);
        drd("R6 pointer held", 16'h5678);

        // R5 zero count
        cmdw(16'h00A2); dwr(16'h0000);
        cmdw(16'h00C0);
        idle_done("R5 immediate pulse", 1'b1);
        dwr(16'h9999);
        status("R5 no data phase", 1'b1);
        clear_err();

        // R8 two-word register, upper word first
        cmdw(16'h00A8); dwr(16'hBEEF); dwr(16'hCAFE);
        cmdw(16'h0028);
        drd("R8 upper word", 16'hBEEF);
        drd("R8 lower word", 16'hCAFE);
        drd("R8 third access ignored", 16'h0000);
        status("R8 third access error", 1'b1);
        clear_err();

        // R10 command during open burst abandons it
        cmdw(16'h00A2); dwr(16'h0006);
        cmdw(16'h00C0); dwr(16'h0101);
        cmdw(16'h00A2); dwr(16'h0002);
        idle_done("R10 no pulse on abandon", 1'b0);
        cmdw(16'h0022);
        drd("R10 new command took effect", 16'h0002);
        status("R10 no error", 1'b0);

        // R1 other addresses and deselected strobes do nothing
        cyc(1'b1, 2'b00, 1'b0, 1'b1, 16'h00A2);
        cyc(1'b1, 2'b01, 1'b0, 1'b1, 16'h0007);
        cyc(1'b0, 2'b11, 1'b0, 1'b1, 16'h00A2);
        cyc(1'b1, 2'b11, 1'b1, 1'b1, 16'h00A2);
        dwr(16'h0007);
        status("R1 no command opened", 1'b1);
        clear_err();
        cmdw(16'h0022);
        drd("R1 count unchanged", 16'h0002);

        // R9 completion pulse coincides with the next command
        cmdw(16'h00C0); dwr(16'h7777);
        cmdw(16'h0040);
        chk("R9 pulse during next command", {15'b0, gdone}, 16'h0001);
        drd("R3 new burst from word zero", 16'h7777);
        idle_done("R9 second pulse", 1'b1);
        idle_done("R9 pulse is one cycle", 1'b0);

        summary();
    end
endmodule